// File: doc/BRIEF.md
# Status Register Write Protect Controller

This block sits between the serial front end and the nonvolatile array of a small serial memory. When chip select returns high, it judges the write sequence that has just ended. A write is accepted only if all of these hold: the write-enable latch is set, the sequence carried a write command, and the sequence delivered a complete number of bytes. An accepted write then passes a protection check before it may start.

Two inputs drive the protection check: the external write-protect pin and a software enable bit held in the status register. The pin blocks status register writes only while the enable bit is 1. Memory array writes are never blocked by either input. An accepted write produces a one-cycle start pulse and holds a busy flag for a programmed number of clock cycles, which stands in for the programming time. Once protection has passed and the cycle has started, nothing can abort it.

When a cycle completes, or when protection rejects a write, the block pulses a clear request to the write-enable latch. The standby indication is high only while chip select is high and no cycle is in progress.

Top module: `sr_wprot_ctrl`

## Requirements
- R1: A status register write (sr_sel_i=1) that is otherwise valid is rejected when wpen_i=1 and wp_i=0. No start pulse follows, and wel_clr_o pulses for one cycle in the cycle after chip select rises.
- R2: With wp_i=1, a valid status register write starts whatever the value of wpen_i.
- R3: With wpen_i=0, wp_i has no effect on any write.
- R4: Memory writes (sr_sel_i=0) start whatever the values of wp_i and wpen_i.
- R5: wr_start_o is a single-cycle pulse in the cycle after chip select rises (cs_n_i 0 to 1, sampled on clk_i). It occurs only if wr_cmd_i=1 and wel_i=1 and the sequence is complete.
- R6: A sequence is complete only when bits_i is a multiple of 8 and is at least SR_BITS (status target) or MEM_BITS (memory target). An incomplete sequence neither starts a cycle nor pulses wel_clr_o.
- R7: busy_o is high for exactly cyc_len_i cycles, starting with the wr_start_o cycle. A value of 0 counts as 1.
- R8: Changes on wp_i, wpen_i or the sequence inputs during a cycle do not shorten or abort it.
- R9: standby_o is high exactly when cs_n_i is high and busy_o is low. A cycle runs to completion while chip select is high.
- R10: wel_clr_o pulses for one cycle in the cycle where busy_o falls.
- R11: A chip select rise while busy_o is high starts no new cycle and causes no rejection.
- R12: After reset, wr_start_o, busy_o and wel_clr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| wp_i | input | 1 | Write-protect pin, 0 = protect |
| wpen_i | input | 1 | Status register protect-enable bit |
| wel_i | input | 1 | Write-enable latch state |
| wr_cmd_i | input | 1 | Sequence carried a write command |
| sr_sel_i | input | 1 | Write targets the status register |
| bits_i | input | BIT_W | Bits received in the sequence |
| cyc_len_i | input | CYC_W | Write cycle length in clocks |
| wr_start_o | output | 1 | Internal write start pulse |
| busy_o | output | 1 | Write cycle in progress |
| standby_o | output | 1 | Deselected and idle |
| wel_clr_o | output | 1 | Clear request for the write-enable latch |

## Verification
The hardest situation to reach is a second chip select rise that arrives mid-cycle while protection inputs move against the running write. The stimulus starts a long memory write first. While it runs, the bench drops the pin, raises the enable bit and pulses chip select low and high with a fully armed write. It then confirms that no new start appears, that busy keeps its full length and that standby stays low. All other cases come from a sweep over every combination of command, target, latch, pin, enable bit, four bit counts around the threshold and three cycle lengths.

// File: rtl/sr_wprot_pkg.sv
package sr_wprot_pkg;
  typedef enum logic [1:0] {
    DEC_NONE   = 2'd0,
    DEC_START  = 2'd1,
    DEC_REJECT = 2'd2
  } wr_dec_e;
endpackage

// File: rtl/sr_wprot_edge.sv
module sr_wprot_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  output logic rise_o
);
  logic cs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_n_q <= 1'b1;
    else         cs_n_q <= cs_n_i;
  end

  assign rise_o = cs_n_i & ~cs_n_q;
endmodule

// File: rtl/sr_wprot_gate.sv
module sr_wprot_gate
  import sr_wprot_pkg::*;
#(
  parameter int BIT_W    = 8,
  parameter int SR_BITS  = 16,
  parameter int MEM_BITS = 32
) (
  input  logic             wp_i,
  input  logic             wpen_i,
  input  logic             wel_i,
  input  logic             wr_cmd_i,
  input  logic             sr_sel_i,
  input  logic [BIT_W-1:0] bits_i,
  output wr_dec_e          dec_o
);
  localparam logic [BIT_W-1:0] SrNeed  = BIT_W'(SR_BITS);
  localparam logic [BIT_W-1:0] MemNeed = BIT_W'(MEM_BITS);

  logic complete, armed, guarded;

  always_comb begin
    complete = (bits_i[2:0] == 3'd0) && (bits_i >= (sr_sel_i ? SrNeed : MemNeed));
    armed    = wr_cmd_i & wel_i & complete;
    // pin only counts when the enable bit is set, and only for status writes
    guarded  = sr_sel_i & wpen_i & ~wp_i;
    if (!armed)       dec_o = DEC_NONE;
    else if (guarded) dec_o = DEC_REJECT;
    else              dec_o = DEC_START;
  end
endmodule

// File: rtl/sr_wprot_timer.sv
module sr_wprot_timer #(
  parameter int CYC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CYC_W-1:0] len_i,
  output logic             busy_o,
  output logic             last_o
);
  logic [CYC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= (len_i == '0) ? CYC_W'(1) : len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CYC_W'(1));

  // R7
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sr_wprot_ctrl.sv
module sr_wprot_ctrl
  import sr_wprot_pkg::*;
#(
  parameter int BIT_W    = 8,
  parameter int CYC_W    = 8,
  parameter int SR_BITS  = 16,
  parameter int MEM_BITS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             wp_i,
  input  logic             wpen_i,
  input  logic             wel_i,
  input  logic             wr_cmd_i,
  input  logic             sr_sel_i,
  input  logic [BIT_W-1:0] bits_i,
  input  logic [CYC_W-1:0] cyc_len_i,
  output logic             wr_start_o,
  output logic             busy_o,
  output logic             standby_o,
  output logic             wel_clr_o
);
  logic    cs_rise, go_start, go_reject, t_last;
  wr_dec_e dec;
  logic    wr_start_q, wel_clr_q;

  sr_wprot_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_n_i(cs_n_i),
    .rise_o(cs_rise)
  );

  sr_wprot_gate #(
    .BIT_W   (BIT_W),
    .SR_BITS (SR_BITS),
    .MEM_BITS(MEM_BITS)
  ) u_gate (
    .wp_i    (wp_i),
    .wpen_i  (wpen_i),
    .wel_i   (wel_i),
    .wr_cmd_i(wr_cmd_i),
    .sr_sel_i(sr_sel_i),
    .bits_i  (bits_i),
    .dec_o   (dec)
  );

  // protection is judged only at the edge, never while a cycle runs
  assign go_start  = cs_rise & ~busy_o & (dec == DEC_START);
  assign go_reject = cs_rise & ~busy_o & (dec == DEC_REJECT);

  sr_wprot_timer #(.CYC_W(CYC_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(go_start),
    .len_i (cyc_len_i),
    .busy_o(busy_o),
    .last_o(t_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_start_q <= 1'b0;
      wel_clr_q  <= 1'b0;
    end else begin
      wr_start_q <= go_start;
      wel_clr_q  <= go_reject | t_last;
    end
  end

  assign wr_start_o = wr_start_q;
  assign wel_clr_o  = wel_clr_q;
  assign standby_o  = cs_n_i & ~busy_o;

  // R5
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |=> !wr_start_o);
  // R7
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |-> busy_o);
  // R10
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> wel_clr_o);
  // R11
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |-> !$past(busy_o));
  // R1
  guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |-> !($past(sr_sel_i) && $past(wpen_i) && !$past(wp_i)));
endmodule

// File: tb/sr_wprot_ctrl_bench.sv
module sr_wprot_ctrl_bench;
  localparam int BIT_W = 8, CYC_W = 8, SRB = 16, MEMB = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wp = 1'b1, wpen = 1'b0, wel = 1'b0, wr_cmd = 1'b0, sr_sel = 1'b0;
  logic [BIT_W-1:0] bits = '0;
  logic [CYC_W-1:0] len = '0;
  logic wr_start, busy, standby, wel_clr;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sr_wprot_ctrl u_sr_wprot_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .wp_i(wp), .wpen_i(wpen),
    .wel_i(wel), .wr_cmd_i(wr_cmd), .sr_sel_i(sr_sel), .bits_i(bits),
    .cyc_len_i(len), .wr_start_o(wr_start), .busy_o(busy),
    .standby_o(standby), .wel_clr_o(wel_clr)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_seq(bit c, bit s, bit l, bit p, bit e, int b, int n);
    bit cmpl, armed, prot, st, rj;
    string tag;
    int cnt, eff;
    wr_cmd = c; sr_sel = s; wel = l; wp = p; wpen = e;
    bits = BIT_W'(b); len = CYC_W'(n);
    cmpl  = (b % 8 == 0) && (b >= (s ? SRB : MEMB));
    armed = c && l && cmpl;
    prot  = s && e && !p;
    st = armed && !prot;
    rj = armed && prot;
    if (!cmpl)         tag = "R6";
    else if (prot)     tag = "R1";
    else if (s && p)   tag = "R2";
    else if (s)        tag = "R3";
    else               tag = "R4";
    cs_n = 1'b0;
    @(negedge clk); @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk({tag, " R5 start"}, int'(wr_start), int'(st));
    chk({tag, " clr"}, int'(wel_clr), int'(rj));
    if (st) begin
      eff = (n == 0) ? 1 : n;
      cnt = 0;
      while (busy && cnt < 300) begin
        cnt++;
        @(negedge clk);
      end
      chk("R7 busy length", cnt, eff);
      chk("R10 clr at end", int'(wel_clr), 1);
      chk("R9 standby idle", int'(standby), 1);
    end else begin
      chk({tag, " no busy"}, int'(busy), 0);
      @(negedge clk);
      chk("R6 no late clr", int'(wel_clr), 0);
    end
    wel = 1'b0; wr_cmd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12
    chk("R12 start", int'(wr_start), 0);
    chk("R12 busy", int'(busy), 0);
    chk("R12 clr", int'(wel_clr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 2; l++)
          for (int p = 0; p < 2; p++)
            for (int e = 0; e < 2; e++)
              for (int bi = 0; bi < 4; bi++)
                for (int ni = 0; ni < 3; ni++) begin
                  int need, b;
                  need = s ? SRB : MEMB;
                  b = (bi == 0) ? need - 8 : (bi == 1) ? need - 1 :
                      (bi == 2) ? need : need + 8;
                  run_seq(c[0], s[0], l[0], p[0], e[0], b, (ni == 0) ? 0 : (ni == 1) ? 1 : 3);
                end

    // R8 R11 R9: disturbance during a running cycle
    begin
      int n;
      wr_cmd = 1; sr_sel = 0; wel = 1; wp = 1; wpen = 0; bits = 8'd32; len = 8'd6;
      cs_n = 1'b0;
      @(negedge clk); @(negedge clk);
      cs_n = 1'b1;
      @(negedge clk);
      chk("R5 start", int'(wr_start), 1);
      @(negedge clk);
      chk("R8 busy", int'(busy), 1);
      cs_n = 1'b0; wp = 1'b0; wpen = 1'b1;
      @(negedge clk);
      chk("R9 standby selected", int'(standby), 0);
      cs_n = 1'b1;
      @(negedge clk);
      chk("R11 no restart", int'(wr_start), 0);
      chk("R11 no reject", int'(wel_clr), 0);
      chk("R9 standby busy", int'(standby), 0);
      n = 4;
      @(negedge clk);
      while (busy && n < 300) begin
        n++;
        @(negedge clk);
      end
      chk("R8 full length", n, 6);
      chk("R10 clr", int'(wel_clr), 1);
      chk("R9 standby after", int'(standby), 1);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule